// File: doc/BRIEF.md
# Programmable Bus Clock Divider

This block produces a free-running output clock taken from the bus clock, divided by a ratio software selects. One 8-bit control word holds a 5-bit ratio code, a switch for an extra divide-by-16 stage, and two active-high disable flags: one for the divided output and one for a double-rate output. The double-rate clock itself is made elsewhere. This block only drives its enable. The word can be read and written in any cycle through a plain synchronous register port. That port uses an address-match select, a write strobe, and write and read data buses. No data stream passes through the block, so there is no valid/ready handshake anywhere. Every pin is a plain control or status pin.

The divided clock is registered in the bus clock domain, which keeps it free of glitches. A new setting is not applied straight away. It is captured only when the running output period ends, so a write never cuts a high or a low phase short. When the division is one (ratio code 0 with the extra stage off), the output follows the bus clock itself. It is passed through a gate whose enable changes only while the bus clock is low. The reset value of the control word depends on a boot-mode input, which is sampled while reset is held.

Top module: `bus_clk_divider`

## Requirements
- R1: While `rst_n` is low with `mode_special` = 0, the control word resets to 0x80. After release `clk_out` stays low and `dbl_rate_en` is 1.
- R2: While `rst_n` is low with `mode_special` = 1, the control word resets to 0x00. After release the output is enabled at the bus clock rate.
- R3: A rising clock edge with `reg_sel` and `reg_we` both high loads all 8 bits of `reg_wdata`. `reg_rdata` shows the whole word while `reg_sel` is high and reads 0 while it is low.
- R4: Bits 4:0 hold a ratio code N. With bit 5 clear and N at least 1, the output period is N+1 bus cycles.
- R5: With bit 5 set, the output period is 16*(N+1) bus cycles, and this includes N = 0.
- R6: In a period of P cycles, the output is high for floor(P/2) cycles followed by ceil(P/2) low cycles. Even periods therefore have a 50% duty cycle, and in odd periods the high phase is one cycle shorter than the low phase.
- R7: Setting bit 7 holds `clk_out` low from the end of the running period onward, with the divider count cleared.
- R8: `dbl_rate_en` is the inverse of bit 6.
- R9: A write to the ratio fields or to bit 7 takes effect only at the end of the running period. The period already under way completes with its old length and duty cycle.
- R10: With bit 7 clear, bit 5 clear and N = 0, `clk_out` is high while `clk` is high and low while `clk` is low.
- R11: A write strobe while `reg_sel` is low leaves the control word and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every register uses its rising edge, except the bypass gate, which updates on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_special | input | 1 | Boot mode sampled during reset: 1 = output enabled, 0 = output disabled |
| reg_sel | input | 1 | Register address match |
| reg_we | input | 1 | Write strobe, valid with `reg_sel` |
| reg_wdata | input | 8 | Write data: bit 7 output off, bit 6 double-rate off, bit 5 extra divide-by-16, bits 4:0 ratio code |
| reg_rdata | output | 8 | Control word while selected, otherwise 0 |
| clk_out | output | 1 | Divided free-running clock |
| dbl_rate_en | output | 1 | Enable for the double-rate clock output |

## Verification
Random control words from a fixed seed cover many ratio codes, with and without the divide-by-16 stage. For each word the bench measures the high and low run lengths of the output. Odd and even ratios are told apart by the asymmetric versus equal phase lengths. Directed cases cover the extreme ratios (2, 32 and 512 cycles) and the unit-ratio pass-through, which is sampled in both clock phases. They also include a mid-period rewrite, which must leave the running period whole before the new ratio appears, and a disable. A second reset in the other boot mode shows that the reset value follows the sampled mode pin.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic {
    BOOT_NORMAL  = 1'b0,
    BOOT_SPECIAL = 1'b1
  } boot_mode_e;

  // Number of flag bits that sit above the ratio code in the control word.
  localparam int FLAG_BITS = 3;

  // The divided output starts disabled only in normal boot mode.
  function automatic logic boot_out_off(boot_mode_e m);
    return (m == BOOT_NORMAL);
  endfunction

endpackage

// File: rtl/bcd_ctrl_reg.sv
module bcd_ctrl_reg
  import bcd_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_special,
  input  logic             sel,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q            <= '0;
      ctrl_q[REG_W-1]   <= boot_out_off(boot_mode_e'(mode_special));
    end else if (sel && we) begin
      ctrl_q <= wdata;
    end
  end

  assign rdata = sel ? ctrl_q : '0;

endmodule

// File: rtl/bcd_ratio_hold.sv
// Computes the period for the requested setting and captures it at a
// period boundary only.
module bcd_ratio_hold #(
  parameter int CODE_W   = 5,
  parameter int PRE_LOG2 = 4,
  localparam int CNT_W   = CODE_W + PRE_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              req_on,
  input  logic              req_pre,
  input  logic [CODE_W-1:0] req_code,
  output logic              cand_start,
  output logic              act_on,
  output logic              act_bypass,
  output logic [CNT_W-1:0]  act_last,
  output logic [CNT_W-1:0]  act_half
);

  logic [CODE_W:0]  base;
  logic [CNT_W-1:0] last_c;
  logic [CNT_W-1:0] half_c;
  logic [CNT_W-1:0] half_pre;
  logic             byp_c;

  assign base = {1'b0, req_code} + (CODE_W+1)'(1);

  generate
    if (PRE_LOG2 > 1) begin : g_half_wide
      assign half_pre = {base, {(PRE_LOG2-1){1'b0}}};
    end else begin : g_half_narrow
      assign half_pre = base;
    end
  endgenerate

  always_comb begin
    if (req_pre) begin
      last_c = {req_code, {PRE_LOG2{1'b1}}};
      half_c = half_pre;
    end else begin
      last_c = {{PRE_LOG2{1'b0}}, req_code};
      half_c = {{PRE_LOG2{1'b0}}, base[CODE_W:1]};
    end
  end

  assign byp_c      = !req_pre && (req_code == '0);
  assign cand_start = req_on && !byp_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_on     <= 1'b0;
      act_bypass <= 1'b0;
      act_last   <= '0;
      act_half   <= '0;
    end else if (take) begin
      act_on     <= req_on;
      act_bypass <= req_on && byp_c;
      act_last   <= last_c;
      act_half   <= half_c;
    end
  end

endmodule

// File: rtl/bcd_phase_counter.sv
module bcd_phase_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_on,
  input  logic [CNT_W-1:0] act_last,
  input  logic [CNT_W-1:0] act_half,
  input  logic             cand_start,
  output logic             period_end,
  output logic [CNT_W-1:0] cnt_q,
  output logic             div_level
);

  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign period_end = !act_on || (cnt_q == act_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      div_level <= 1'b0;
    end else if (period_end) begin
      cnt_q     <= '0;
      div_level <= cand_start;
    end else begin
      cnt_q     <= cnt_inc;
      div_level <= (cnt_inc < act_half);
    end
  end

endmodule

// File: rtl/bcd_out_stage.sv
// Merges the registered divided level with a gated copy of the bus clock
// used for the unit ratio; the gate enable moves only while clk is low.
module bcd_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic act_bypass,
  input  logic div_level,
  output logic clk_out
);

  logic gate_q;

  always_ff @(negedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= act_bypass;
  end

  assign clk_out = (gate_q & clk) | div_level;

endmodule

// File: rtl/bus_clk_divider.sv
module bus_clk_divider
  import bcd_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int PRE_LOG2 = 4,
  localparam int REG_W   = CODE_W + FLAG_BITS,
  localparam int CNT_W   = CODE_W + PRE_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_special,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             clk_out,
  output logic             dbl_rate_en
);

  localparam int BIT_OUT_OFF = REG_W - 1;
  localparam int BIT_DBL_OFF = REG_W - 2;
  localparam int BIT_PRE     = REG_W - 3;

  logic [REG_W-1:0] ctrl_q;
  logic             period_end;
  logic             cand_start;
  logic             act_on;
  logic             act_bypass;
  logic [CNT_W-1:0] act_last;
  logic [CNT_W-1:0] act_half;
  logic [CNT_W-1:0] cnt_q;
  logic             div_level;

  bcd_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_special (mode_special),
    .sel          (reg_sel),
    .we           (reg_we),
    .wdata        (reg_wdata),
    .ctrl_q       (ctrl_q),
    .rdata        (reg_rdata)
  );

  bcd_ratio_hold #(.CODE_W(CODE_W), .PRE_LOG2(PRE_LOG2)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (period_end),
    .req_on     (!ctrl_q[BIT_OUT_OFF]),
    .req_pre    (ctrl_q[BIT_PRE]),
    .req_code   (ctrl_q[CODE_W-1:0]),
    .cand_start (cand_start),
    .act_on     (act_on),
    .act_bypass (act_bypass),
    .act_last   (act_last),
    .act_half   (act_half)
  );

  bcd_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_on     (act_on),
    .act_last   (act_last),
    .act_half   (act_half),
    .cand_start (cand_start),
    .period_end (period_end),
    .cnt_q      (cnt_q),
    .div_level  (div_level)
  );

  bcd_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_bypass (act_bypass),
    .div_level  (div_level),
    .clk_out    (clk_out)
  );

  assign dbl_rate_en = !ctrl_q[BIT_DBL_OFF];

endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
  parameter int REG_W = 8,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             we,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] ctrl,
  input logic             period_end,
  input logic             act_on,
  input logic             act_bypass,
  input logic [CNT_W-1:0] act_last,
  input logic [CNT_W-1:0] cnt,
  input logic             div_level
);

  assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we) |=> (ctrl == $past(wdata)));

  assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && we) |=> $stable(ctrl));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_on |-> (cnt <= act_last));

  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !act_on |-> (!div_level && cnt == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(act_last) && $stable(act_on)));

  assert_bypass_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_bypass |-> !div_level);

endmodule

bind bus_clk_divider bcd_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (reg_sel),
  .we         (reg_we),
  .wdata      (reg_wdata),
  .ctrl       (ctrl_q),
  .period_end (period_end),
  .act_on     (act_on),
  .act_bypass (act_bypass),
  .act_last   (act_last),
  .cnt        (cnt_q),
  .div_level  (div_level)
);

// File: tb/bus_clk_divider_tb.sv
`timescale 1ns/1ps
module bus_clk_divider_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_special = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       clk_out;
  logic       dbl_rate_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_clk_divider u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_special (mode_special),
    .reg_sel      (reg_sel),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .clk_out      (clk_out),
    .dbl_rate_en  (dbl_rate_en)
  );

  function automatic int exp_period(int code, bit pre);
    return (code + 1) * (pre ? 16 : 1);
  endfunction

  function automatic int exp_high(int code, bit pre);
    return exp_period(code, pre) / 2;
  endfunction

  function automatic int exp_low(int code, bit pre);
    return exp_period(code, pre) - exp_high(code, pre);
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    mode_special = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_reg(logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic read_reg(output int v);
    @(negedge clk);
    reg_sel = 1'b1;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic sample(output bit s);
    @(negedge clk);
    #1 s = clk_out;
  endtask

  // Finds a rising edge of the output, then counts high and low samples
  // until the next rise.
  task automatic measure(output int hi, output int lo);
    bit prev, s;
    hi = 0; lo = 0;
    sample(prev);
    for (int i = 0; i < 1200; i++) begin
      sample(s);
      if (!prev && s) break;
      prev = s;
    end
    hi = 1;
    sample(s);
    for (int i = 0; i < 600 && s; i++) begin hi++; sample(s); end
    for (int i = 0; i < 600 && !s; i++) begin lo++; sample(s); end
  endtask

  task automatic count_high(int n, output int highs);
    bit s;
    highs = 0;
    for (int i = 0; i < n; i++) begin sample(s); if (s) highs++; end
  endtask

  task automatic check_bypass(string tag);
    int bad = 0;
    repeat (5) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2 if (clk_out !== 1'b1) bad++;
      @(negedge clk); #2 if (clk_out !== 1'b0) bad++;
    end
    check_eq(tag, bad, 0);
  endtask

  task automatic check_ratio(string tag, int code, bit pre);
    int hi, lo;
    measure(hi, lo);
    measure(hi, lo);
    check_eq({tag, " high"}, hi, exp_high(code, pre));
    check_eq({tag, " low"},  lo, exp_low(code, pre));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int v, hi, lo, highs;
    bit s;
    int unsigned seed = 32'h5EED_C10C;
    void'($urandom(seed));

    // R1: normal boot mode
    do_reset(1'b0);
    read_reg(v);
    check_eq("R1 reset word", v, 8'h80);
    check_eq("R1 dbl_rate_en", int'(dbl_rate_en), 1);
    count_high(20, highs);
    check_eq("R1 output low", highs, 0);

    // R4/R6 directed ratios
    write_reg(8'h01); check_ratio("R4 R6 div2", 1, 1'b0);
    write_reg(8'h02); check_ratio("R6 div3 odd", 2, 1'b0);
    write_reg(8'h1F); check_ratio("R4 div32", 31, 1'b0);
    write_reg(8'h3F); check_ratio("R5 div512", 31, 1'b1);
    write_reg(8'h20); check_ratio("R5 pre code0", 0, 1'b1);

    // R9: rewrite in the middle of a period of 10
    write_reg(8'h09);
    measure(hi, lo);
    reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 8'h01;
    sample(s);
    reg_sel = 1'b0; reg_we = 1'b0;
    hi = 1;
    for (int i = 0; i < 40 && s; i++) begin hi++; sample(s); end
    lo = 0;
    for (int i = 0; i < 40 && !s; i++) begin lo++; sample(s); end
    check_eq("R9 old period high", hi, 5);
    check_eq("R9 old period low", lo, 5);
    measure(hi, lo);
    check_eq("R9 new period high", hi, 1);
    check_eq("R9 new period low", lo, 1);

    // Random ratios: R4 R5 R6 R3 R8
    for (int it = 0; it < 12; it++) begin
      int code = int'($urandom % 32);
      bit pre = (($urandom % 4) == 0);
      bit dbl = $urandom % 2;
      logic [7:0] w;
      if (code == 0 && !pre) code = 1;
      w = {1'b0, dbl, pre, 5'(code)};
      write_reg(w);
      read_reg(v);
      check_eq("R3 readback", v, int'(w));
      check_eq("R8 dbl_rate_en", int'(dbl_rate_en), int'(!dbl));
      check_ratio(pre ? "R5 R6 random" : "R4 R6 random", code, pre);
    end

    // R7: disable
    write_reg(8'h83);
    repeat (10) @(negedge clk);
    count_high(40, highs);
    check_eq("R7 disabled output low", highs, 0);

    // R8: double-rate disable
    write_reg(8'hC0);
    read_reg(v);
    check_eq("R8 word", v, 8'hC0);
    check_eq("R8 dbl_rate_en off", int'(dbl_rate_en), 0);

    // R11: write without select, R3: read without select
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 8'h15;
    @(negedge clk);
    reg_we = 1'b0;
    #1 check_eq("R3 unselected read zero", int'(reg_rdata), 0);
    read_reg(v);
    check_eq("R11 word unchanged", v, 8'hC0);
    count_high(20, highs);
    check_eq("R11 output still low", highs, 0);
    check_eq("R11 dbl_rate_en unchanged", int'(dbl_rate_en), 0);

    // R10: unit ratio follows the bus clock
    write_reg(8'h00);
    check_bypass("R10 pass-through");
    write_reg(8'h04); check_ratio("R4 after pass-through", 4, 1'b0);

    // R2: special boot mode
    do_reset(1'b1);
    read_reg(v);
    check_eq("R2 reset word", v, 8'h00);
    check_eq("R2 dbl_rate_en", int'(dbl_rate_en), 1);
    check_bypass("R2 enabled at bus rate");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule